// File: doc/BRIEF.md
# Test-Board Clock and Data Routing Matrix

This block sits in the glue logic of a line-interface test board. A host writes byte-wide registers over a simple parallel port with an 8-bit address, 8-bit data and separate read and write strobes. For each of eight line ports it chooses where the transmit clock, the positive transmit rail and the negative transmit rail come from. For the on-board bit-error tester it chooses the sources of the transmit clock, the receive clock and the receive data. It also drives the line device's master clock, output-enable, mode, bit-order and clock-edge pins, and the LED that shows loss of signal on port 1.

Every routed output is a combinational multiplexer plus an output-enable flag. When the enable is low the data output is held at 0, and the pad logic outside the block turns that into high impedance. The per-port selects are not mapped one register per port. They are reached through a bank pointer: the host writes the port index to the pointer and then accesses three window offsets. Every select uses one shared 8-bit code space:

| Code | Source |
|---|---|
| 0x00–0x07 | Port n+1 (recovered clock, positive receive data or negative receive data, depending on the select) |
| 0x10 | 1.544 MHz oscillator |
| 0x11 | 2.048 MHz oscillator |
| 0x12 | User clock |
| 0x13 | Device clock A |
| 0x14 | Device transmit-equipment clock |
| 0x15 | Per-signal special code |
| Any other value | Disabled |

Read data is combinational. It is valid while the read strobe is high and is 0x00 at all other times. The port count parameter `NPORT` must not exceed 8, because codes 0x00–0x07 are the only port codes.

Top module: `clk_route_matrix`

## Requirements
- R1: After reset, every per-port and tester select holds 0x08, the bank pointer and the control register read 0x00, and every routed output-enable and `mclk_oe` is low.
- R2: Reads of the identity offsets return fixed values: 0x00 returns 0x0D, 0x02 returns 0x00, 0x03 returns 0x01 and 0x04 returns 0x06. Offsets 0x05, 0x06 and 0x07 return the board, assembly and firmware revision parameters.
- R3: Offset 0x0A is the bank pointer. Offsets 0x10, 0x11 and 0x12 read and write the clock, positive-rail and negative-rail selects of the port that the pointer names (value n selects port n+1).
- R4: Codes 0x00–0x07 route bit n of `rx_clk` to a clock output, bit n of `rx_pos` to a positive-rail output and bit n of `rx_neg` to a negative-rail output, with the enable high.
- R5: Codes 0x08–0x0F and 0x16–0xFF drive the enable low and the output to 0.
- R6: Codes 0x10–0x14 route, in that order, `osc_t1`, `osc_e1`, `usr_clk`, `dev_clka` and `dev_teclk`, with the enable high.
- R7: Code 0x15 routes `tst_tclk_out` to port clocks, `tst_tdat_out` to positive rails and a constant 0 to negative rails, with the enable high in every case.
- R8: Offsets 0x0B, 0x0C and 0x0D select the tester transmit clock, receive clock and receive data. They use the port-clock, port-clock and positive-rail port sources respectively, and code 0x15 gives `tst_tclk_out` for all three.
- R9: Control register 0x08 bits 1:0 select the master clock: 00 disabled, 01 `osc_t1`, 10 `osc_e1`, 11 `usr_clk`.
- R10: Bit 2 of 0x08 drives `dev_oe`. Bit 3 selects serial mode and drives `dev_mode` to its inverse. Bit 4 drives `dev_swap` and bit 5 drives `dev_edge`, but only while bit 3 is 1; otherwise both are 0.
- R11: Bit 6 of 0x08 lets `los_led` follow `dev_los1`. Reads of 0x08 return `dev_irq` in bit 7, and writes to bit 7 have no effect.
- R12: Writes to the identity offsets and to unassigned offsets change nothing, and reads of unassigned offsets return 0x00.
- R13: While the bank pointer is above 0x07, the window offsets read 0x00 and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_addr | input | 8 | Host register offset |
| hst_wdata | input | 8 | Host write data |
| hst_wr | input | 1 | Write strobe; takes effect on the rising clock edge |
| hst_rd | input | 1 | Read strobe |
| hst_rdata | output | 8 | Read data; 0x00 while no read is in progress |
| rx_clk | input | NPORT | Recovered clock from each port |
| rx_pos | input | NPORT | Positive receive data from each port |
| rx_neg | input | NPORT | Negative receive data from each port |
| osc_t1 | input | 1 | 1.544 MHz oscillator |
| osc_e1 | input | 1 | 2.048 MHz oscillator |
| usr_clk | input | 1 | User clock |
| dev_clka | input | 1 | Line device clock A |
| dev_teclk | input | 1 | Line device transmit-equipment clock |
| tst_tclk_out | input | 1 | Transmit clock from the error tester |
| tst_tdat_out | input | 1 | Transmit data from the error tester |
| dev_irq | input | 1 | Line device interrupt |
| dev_los1 | input | 1 | Port 1 loss of signal |
| port_tclk | output | NPORT | Routed transmit clock for each port |
| port_tclk_oe | output | NPORT | Enable for each routed transmit clock |
| port_tpos | output | NPORT | Routed positive rail for each port |
| port_tpos_oe | output | NPORT | Enable for each routed positive rail |
| port_tneg | output | NPORT | Routed negative rail for each port |
| port_tneg_oe | output | NPORT | Enable for each routed negative rail |
| tst_tclk | output | 1 | Routed tester transmit clock |
| tst_tclk_oe | output | 1 | Enable for the tester transmit clock |
| tst_rclk | output | 1 | Routed tester receive clock |
| tst_rclk_oe | output | 1 | Enable for the tester receive clock |
| tst_rdat | output | 1 | Routed tester receive data |
| tst_rdat_oe | output | 1 | Enable for the tester receive data |
| mclk | output | 1 | Routed master clock |
| mclk_oe | output | 1 | Enable for the master clock |
| dev_oe | output | 1 | Line device output-enable pin |
| dev_mode | output | 1 | Line device mode pin (1 = parallel) |
| dev_swap | output | 1 | Line device bit-order pin |
| dev_edge | output | 1 | Line device serial clock-edge pin |
| los_led | output | 1 | Port 1 loss-of-signal LED |

## Verification
The bench targets the following corner cases:

- **Edges of the code space.** It drives 0x07, 0x08, 0x0F, 0x14, 0x15, 0x16 and 0xFF on every select. A decoder that treats 0x08 as a port code, or that lets the high-impedance gaps fall through to a fixed source, shows up as a raised enable.
- **Code 0x15.** This code is checked on all six select types. A design that treats the negative-rail special code like the positive one leaks tester data instead of a driven 0.
- **Bank pointer.** The bench parks the pointer above 0x07 and writes through the window. It then reads every port back, which catches an index that is truncated to three bits and lands on a real port.
- **Control register.** All 256 values go through the control register. A design that does not gate bit order and clock edge with serial mode, or that stores bit 7, miscompares against the model.

// File: rtl/crm_pkg.sv
package crm_pkg;

  // register offsets
  localparam logic [7:0] A_BOARD_ID  = 8'h00;
  localparam logic [7:0] A_XID_HI    = 8'h02;
  localparam logic [7:0] A_XID_MID   = 8'h03;
  localparam logic [7:0] A_XID_LO    = 8'h04;
  localparam logic [7:0] A_REV_BOARD = 8'h05;
  localparam logic [7:0] A_REV_ASSY  = 8'h06;
  localparam logic [7:0] A_REV_FW    = 8'h07;
  localparam logic [7:0] A_CTRL      = 8'h08;
  localparam logic [7:0] A_BANK      = 8'h0A;
  localparam logic [7:0] A_TST_TCLK  = 8'h0B;
  localparam logic [7:0] A_TST_RCLK  = 8'h0C;
  localparam logic [7:0] A_TST_RDAT  = 8'h0D;
  localparam logic [7:0] A_WIN_TCLK  = 8'h10;
  localparam logic [7:0] A_WIN_TPOS  = 8'h11;
  localparam logic [7:0] A_WIN_TNEG  = 8'h12;

  // identity constants
  localparam logic [7:0] ID_BOARD   = 8'h0D;
  localparam logic [7:0] ID_XID_HI  = 8'h00;
  localparam logic [7:0] ID_XID_MID = 8'h01;
  localparam logic [7:0] ID_XID_LO  = 8'h06;

  // source codes
  localparam logic [7:0] SRC_OFF_RST = 8'h08;
  localparam logic [7:0] SRC_T1      = 8'h10;
  localparam logic [7:0] SRC_E1      = 8'h11;
  localparam logic [7:0] SRC_USR     = 8'h12;
  localparam logic [7:0] SRC_CLKA    = 8'h13;
  localparam logic [7:0] SRC_TECLK   = 8'h14;
  localparam logic [7:0] SRC_SPECIAL = 8'h15;

  // tester select slots
  localparam int TST_SLOTS = 3;
  localparam int SLOT_TCLK = 0;
  localparam int SLOT_RCLK = 1;
  localparam int SLOT_RDAT = 2;

  typedef struct packed {
    logic osc_t1;
    logic osc_e1;
    logic usr;
    logic clka;
    logic teclk;
  } fixed_src_t;

  // bit order matches control register bits 6..0
  typedef struct packed {
    logic       los_led_en;
    logic       edge_sel;
    logic       swap;
    logic       serial;
    logic       oe;
    logic [1:0] mclk_sel;
  } ctrl_t;

endpackage

// File: rtl/crm_src_mux.sv
module crm_src_mux
  import crm_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic [7:0]       code,
  input  logic [NPORT-1:0] port_sig,
  input  fixed_src_t       fix,
  input  logic             special,
  output logic             sig_o,
  output logic             oe_o
);

  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

  always_comb begin
    sig_o = 1'b0;
    oe_o  = 1'b0;
    if (code < 8'(NPORT)) begin
      sig_o = port_sig[code[IW-1:0]];
      oe_o  = 1'b1;
    end else begin
      case (code)
        SRC_T1:      begin sig_o = fix.osc_t1; oe_o = 1'b1; end
        SRC_E1:      begin sig_o = fix.osc_e1; oe_o = 1'b1; end
        SRC_USR:     begin sig_o = fix.usr;    oe_o = 1'b1; end
        SRC_CLKA:    begin sig_o = fix.clka;   oe_o = 1'b1; end
        SRC_TECLK:   begin sig_o = fix.teclk;  oe_o = 1'b1; end
        SRC_SPECIAL: begin sig_o = special;    oe_o = 1'b1; end
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/crm_regs.sv
module crm_regs
  import crm_pkg::*;
#(
  parameter int         NPORT     = 8,
  parameter logic [7:0] BOARD_REV = 8'h01,
  parameter logic [7:0] ASSY_REV  = 8'h01,
  parameter logic [7:0] FW_REV    = 8'h01
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hst_wr,
  input  logic                      hst_rd,
  input  logic [7:0]                hst_addr,
  input  logic [7:0]                hst_wdata,
  output logic [7:0]                hst_rdata,
  input  logic                      dev_irq,
  output logic [NPORT-1:0][7:0]     sel_tclk,
  output logic [NPORT-1:0][7:0]     sel_tpos,
  output logic [NPORT-1:0][7:0]     sel_tneg,
  output logic [TST_SLOTS-1:0][7:0] sel_tst,
  output ctrl_t                     ctrl
);

  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [7:0]    bank_ptr;
  logic          ptr_ok;
  logic [IW-1:0] idx;

  assign ptr_ok = bank_ptr < 8'(NPORT);
  assign idx    = bank_ptr[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_tclk <= {NPORT{SRC_OFF_RST}};
      sel_tpos <= {NPORT{SRC_OFF_RST}};
      sel_tneg <= {NPORT{SRC_OFF_RST}};
      sel_tst  <= {TST_SLOTS{SRC_OFF_RST}};
      bank_ptr <= 8'h00;
      ctrl     <= '0;
    end else if (hst_wr) begin
      case (hst_addr)
        A_CTRL:     ctrl              <= hst_wdata[6:0];
        A_BANK:     bank_ptr          <= hst_wdata;
        A_TST_TCLK: sel_tst[SLOT_TCLK] <= hst_wdata;
        A_TST_RCLK: sel_tst[SLOT_RCLK] <= hst_wdata;
        A_TST_RDAT: sel_tst[SLOT_RDAT] <= hst_wdata;
        A_WIN_TCLK: if (ptr_ok) sel_tclk[idx] <= hst_wdata;
        A_WIN_TPOS: if (ptr_ok) sel_tpos[idx] <= hst_wdata;
        A_WIN_TNEG: if (ptr_ok) sel_tneg[idx] <= hst_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    hst_rdata = 8'h00;
    if (hst_rd) begin
      case (hst_addr)
        A_BOARD_ID:  hst_rdata = ID_BOARD;
        A_XID_HI:    hst_rdata = ID_XID_HI;
        A_XID_MID:   hst_rdata = ID_XID_MID;
        A_XID_LO:    hst_rdata = ID_XID_LO;
        A_REV_BOARD: hst_rdata = BOARD_REV;
        A_REV_ASSY:  hst_rdata = ASSY_REV;
        A_REV_FW:    hst_rdata = FW_REV;
        A_CTRL:      hst_rdata = {dev_irq, ctrl};
        A_BANK:      hst_rdata = bank_ptr;
        A_TST_TCLK:  hst_rdata = sel_tst[SLOT_TCLK];
        A_TST_RCLK:  hst_rdata = sel_tst[SLOT_RCLK];
        A_TST_RDAT:  hst_rdata = sel_tst[SLOT_RDAT];
        A_WIN_TCLK:  hst_rdata = ptr_ok ? sel_tclk[idx] : 8'h00;
        A_WIN_TPOS:  hst_rdata = ptr_ok ? sel_tpos[idx] : 8'h00;
        A_WIN_TNEG:  hst_rdata = ptr_ok ? sel_tneg[idx] : 8'h00;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/clk_route_matrix.sv
module clk_route_matrix
  import crm_pkg::*;
#(
  parameter int         NPORT     = 8,
  parameter logic [7:0] BOARD_REV = 8'h01,
  parameter logic [7:0] ASSY_REV  = 8'h01,
  parameter logic [7:0] FW_REV    = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       hst_addr,
  input  logic [7:0]       hst_wdata,
  input  logic             hst_wr,
  input  logic             hst_rd,
  output logic [7:0]       hst_rdata,
  input  logic [NPORT-1:0] rx_clk,
  input  logic [NPORT-1:0] rx_pos,
  input  logic [NPORT-1:0] rx_neg,
  input  logic             osc_t1,
  input  logic             osc_e1,
  input  logic             usr_clk,
  input  logic             dev_clka,
  input  logic             dev_teclk,
  input  logic             tst_tclk_out,
  input  logic             tst_tdat_out,
  input  logic             dev_irq,
  input  logic             dev_los1,
  output logic [NPORT-1:0] port_tclk,
  output logic [NPORT-1:0] port_tclk_oe,
  output logic [NPORT-1:0] port_tpos,
  output logic [NPORT-1:0] port_tpos_oe,
  output logic [NPORT-1:0] port_tneg,
  output logic [NPORT-1:0] port_tneg_oe,
  output logic             tst_tclk,
  output logic             tst_tclk_oe,
  output logic             tst_rclk,
  output logic             tst_rclk_oe,
  output logic             tst_rdat,
  output logic             tst_rdat_oe,
  output logic             mclk,
  output logic             mclk_oe,
  output logic             dev_oe,
  output logic             dev_mode,
  output logic             dev_swap,
  output logic             dev_edge,
  output logic             los_led
);

  logic [NPORT-1:0][7:0]     sel_tclk;
  logic [NPORT-1:0][7:0]     sel_tpos;
  logic [NPORT-1:0][7:0]     sel_tneg;
  logic [TST_SLOTS-1:0][7:0] sel_tst;
  ctrl_t                     ctrl;
  fixed_src_t                fix;

  assign fix = '{osc_t1: osc_t1, osc_e1: osc_e1, usr: usr_clk,
                 clka: dev_clka, teclk: dev_teclk};

  crm_regs #(
    .NPORT(NPORT), .BOARD_REV(BOARD_REV), .ASSY_REV(ASSY_REV), .FW_REV(FW_REV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .dev_irq(dev_irq), .sel_tclk(sel_tclk), .sel_tpos(sel_tpos),
    .sel_tneg(sel_tneg), .sel_tst(sel_tst), .ctrl(ctrl)
  );

  // one clock, positive and negative rail selector per port
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    crm_src_mux #(.NPORT(NPORT)) u_tclk (
      .code(sel_tclk[p]), .port_sig(rx_clk), .fix(fix), .special(tst_tclk_out),
      .sig_o(port_tclk[p]), .oe_o(port_tclk_oe[p]));
    crm_src_mux #(.NPORT(NPORT)) u_tpos (
      .code(sel_tpos[p]), .port_sig(rx_pos), .fix(fix), .special(tst_tdat_out),
      .sig_o(port_tpos[p]), .oe_o(port_tpos_oe[p]));
    crm_src_mux #(.NPORT(NPORT)) u_tneg (
      .code(sel_tneg[p]), .port_sig(rx_neg), .fix(fix), .special(1'b0),
      .sig_o(port_tneg[p]), .oe_o(port_tneg_oe[p]));
  end

  crm_src_mux #(.NPORT(NPORT)) u_tst_tclk (
    .code(sel_tst[SLOT_TCLK]), .port_sig(rx_clk), .fix(fix), .special(tst_tclk_out),
    .sig_o(tst_tclk), .oe_o(tst_tclk_oe));
  crm_src_mux #(.NPORT(NPORT)) u_tst_rclk (
    .code(sel_tst[SLOT_RCLK]), .port_sig(rx_clk), .fix(fix), .special(tst_tclk_out),
    .sig_o(tst_rclk), .oe_o(tst_rclk_oe));
  crm_src_mux #(.NPORT(NPORT)) u_tst_rdat (
    .code(sel_tst[SLOT_RDAT]), .port_sig(rx_pos), .fix(fix), .special(tst_tclk_out),
    .sig_o(tst_rdat), .oe_o(tst_rdat_oe));

  always_comb begin
    case (ctrl.mclk_sel)
      2'b01:   begin mclk = osc_t1;  mclk_oe = 1'b1; end
      2'b10:   begin mclk = osc_e1;  mclk_oe = 1'b1; end
      2'b11:   begin mclk = usr_clk; mclk_oe = 1'b1; end
      default: begin mclk = 1'b0;    mclk_oe = 1'b0; end
    endcase
  end

  assign dev_oe   = ctrl.oe;
  assign dev_mode = ~ctrl.serial;
  assign dev_swap = ctrl.serial & ctrl.swap;
  assign dev_edge = ctrl.serial & ctrl.edge_sel;
  assign los_led  = ctrl.los_led_en & dev_los1;

endmodule

// File: rtl/crm_chk.sv
module crm_chk
  import crm_pkg::*;
#(
  parameter int NPORT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       hst_addr,
  input logic [7:0]       hst_wdata,
  input logic             hst_wr,
  input logic             hst_rd,
  input logic [7:0]       hst_rdata,
  input logic [NPORT-1:0] port_tneg,
  input logic [NPORT-1:0] port_tneg_oe,
  input logic             mclk,
  input logic             mclk_oe,
  input logic             dev_mode,
  input logic             dev_swap,
  input logic             dev_edge,
  input logic             dev_los1,
  input logic             los_led
);

  // R10
  serial_pins_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_mode |-> (!dev_swap && !dev_edge));

  // R10
  mode_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr == A_CTRL) |=> (dev_mode == !$past(hst_wdata[3])));

  // R9
  mclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_oe |-> !mclk);

  // R9
  mclk_off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr == A_CTRL && hst_wdata[1:0] == 2'b00) |=> !mclk_oe);

  // R11
  led_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_los1 |-> !los_led);

  // R2
  board_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && hst_addr == A_BOARD_ID) |-> (hst_rdata == ID_BOARD));

  // R5
  tneg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_tneg & ~port_tneg_oe) == '0);

  // R12
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_rd |-> (hst_rdata == 8'h00));

endmodule

bind clk_route_matrix crm_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/sim_clk_route_matrix.sv
`timescale 1ns/1ps
module sim_clk_route_matrix;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] hst_addr = 8'h00, hst_wdata = 8'h00;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [7:0] hst_rdata;
  logic [31:0] pat = 32'h1234_5679;
  logic [7:0] rx_clk, rx_pos, rx_neg;
  logic osc_t1, osc_e1, usr_clk, dev_clka, dev_teclk, tst_tclk_out, tst_tdat_out, dev_irq, dev_los1;
  logic [7:0] port_tclk, port_tclk_oe, port_tpos, port_tpos_oe, port_tneg, port_tneg_oe;
  logic tst_tclk, tst_tclk_oe, tst_rclk, tst_rclk_oe, tst_rdat, tst_rdat_oe;
  logic mclk, mclk_oe, dev_oe, dev_mode, dev_swap, dev_edge, los_led;

  int nvec = 0, nfail = 0;
  bit cmp_on = 0, done = 0;

  always #4 clk = ~clk;

  assign rx_clk = pat[7:0];
  assign rx_pos = pat[15:8];
  assign rx_neg = pat[23:16];
  assign {osc_t1, osc_e1, usr_clk, dev_clka, dev_teclk, tst_tclk_out, tst_tdat_out, dev_irq}
         = pat[31:24];
  assign dev_los1 = pat[3] ^ pat[17];

  always @(posedge clk) begin
    #1;
    pat = pat ^ (pat << 13);
    pat = pat ^ (pat >> 17);
    pat = pat ^ (pat << 5);
  end

  clk_route_matrix u0 (.*);

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_tclk [8], m_tpos [8], m_tneg [8], m_tst [3];
  logic [7:0] m_ptr, m_ctrl;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_tclk[i] = 8'h08; m_tpos[i] = 8'h08; m_tneg[i] = 8'h08; end
    for (int i = 0; i < 3; i++) m_tst[i] = 8'h08;
    m_ptr = 0; m_ctrl = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (hst_wr) begin
      case (hst_addr)
        8'h08: m_ctrl = hst_wdata & 8'h7F;
        8'h0A: m_ptr = hst_wdata;
        8'h0B: m_tst[0] = hst_wdata;
        8'h0C: m_tst[1] = hst_wdata;
        8'h0D: m_tst[2] = hst_wdata;
        8'h10: if (m_ptr < 8) m_tclk[m_ptr] = hst_wdata;
        8'h11: if (m_ptr < 8) m_tpos[m_ptr] = hst_wdata;
        8'h12: if (m_ptr < 8) m_tneg[m_ptr] = hst_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] route(logic [7:0] code, logic [7:0] vec, logic spec);
    if (code < 8) return {6'd0, 1'b1, vec[code]};
    case (code)
      8'h10: return {6'd0, 1'b1, osc_t1};
      8'h11: return {6'd0, 1'b1, osc_e1};
      8'h12: return {6'd0, 1'b1, usr_clk};
      8'h13: return {6'd0, 1'b1, dev_clka};
      8'h14: return {6'd0, 1'b1, dev_teclk};
      8'h15: return {6'd0, 1'b1, spec};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string ctag(logic [7:0] code);
    if (code < 8) return "R4";
    if (code >= 8'h10 && code <= 8'h14) return "R6";
    if (code == 8'h15) return "R7";
    return "R5";
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return 8'h0D;
      8'h02: return 8'h00;
      8'h03: return 8'h01;
      8'h04: return 8'h06;
      8'h05, 8'h06, 8'h07: return 8'h01;
      8'h08: return {dev_irq, m_ctrl[6:0]};
      8'h0A: return m_ptr;
      8'h0B: return m_tst[0];
      8'h0C: return m_tst[1];
      8'h0D: return m_tst[2];
      8'h10: return (m_ptr < 8) ? m_tclk[m_ptr] : 8'h00;
      8'h11: return (m_ptr < 8) ? m_tpos[m_ptr] : 8'h00;
      8'h12: return (m_ptr < 8) ? m_tneg[m_ptr] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string atag(logic [7:0] a);
    if (a <= 8'h07 && a != 8'h01) return "R2";
    if (a == 8'h08) return "R11";
    if (a == 8'h0A) return "R3";
    if (a >= 8'h0B && a <= 8'h0D) return "R8";
    if (a >= 8'h10 && a <= 8'h12) return (m_ptr < 8) ? "R3" : "R13";
    return "R12";
  endfunction

  task automatic cmp(string tag, logic [7:0] got, logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // compare every output against the model on every clock
  always @(negedge clk) if (cmp_on && !done) begin
    logic [7:0] c;
    for (int p = 0; p < 8; p++) begin
      cmp(ctag(m_tclk[p]), {6'd0, port_tclk_oe[p], port_tclk[p]}, route(m_tclk[p], rx_clk, tst_tclk_out));
      cmp(ctag(m_tpos[p]), {6'd0, port_tpos_oe[p], port_tpos[p]}, route(m_tpos[p], rx_pos, tst_tdat_out));
      cmp(ctag(m_tneg[p]), {6'd0, port_tneg_oe[p], port_tneg[p]}, route(m_tneg[p], rx_neg, 1'b0));
    end
    cmp("R8", {6'd0, tst_tclk_oe, tst_tclk}, route(m_tst[0], rx_clk, tst_tclk_out));
    cmp("R8", {6'd0, tst_rclk_oe, tst_rclk}, route(m_tst[1], rx_clk, tst_tclk_out));
    cmp("R8", {6'd0, tst_rdat_oe, tst_rdat}, route(m_tst[2], rx_pos, tst_tclk_out));
    c = m_ctrl;
    case (c[1:0])
      2'b00: cmp("R9", {6'd0, mclk_oe, mclk}, 8'h00);
      2'b01: cmp("R9", {6'd0, mclk_oe, mclk}, {6'd0, 1'b1, osc_t1});
      2'b10: cmp("R9", {6'd0, mclk_oe, mclk}, {6'd0, 1'b1, osc_e1});
      default: cmp("R9", {6'd0, mclk_oe, mclk}, {6'd0, 1'b1, usr_clk});
    endcase
    cmp("R10", {4'd0, dev_oe, dev_mode, dev_swap, dev_edge},
        {4'd0, c[2], !c[3], c[3] & c[4], c[3] & c[5]});
    cmp("R11", {7'd0, los_led}, {7'd0, c[6] & dev_los1});
    cmp(hst_rd ? atag(hst_addr) : "R12", hst_rdata, hst_rd ? exp_rd(hst_addr) : 8'h00);
  end

  // ---------------- host tasks ----------------
  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    hst_rd = 1; hst_addr = a;
    @(negedge clk);
    v = hst_rdata;
    @(posedge clk); #1;
    hst_rd = 0;
  endtask

  logic [7:0] codes [18] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                             8'h08, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15,
                             8'h16, 8'hFF};

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", port_tclk_oe | port_tpos_oe | port_tneg_oe, 8'h00);
    cmp("R1", {5'd0, mclk_oe, tst_tclk_oe, tst_rdat_oe}, 8'h00);
    rd(8'h0A, v); cmp("R1", v, 8'h00);
    rd(8'h08, v); cmp("R1", v & 8'h7F, 8'h00);
    rd(8'h10, v); cmp("R1", v, 8'h08);
    rd(8'h0C, v); cmp("R1", v, 8'h08);
    // R2 identity and R12 unassigned reads
    for (int a = 0; a < 32; a++) rd(8'(a), v);
    rd(8'h03, v); cmp("R2", v, 8'h01);
    rd(8'h04, v); cmp("R2", v, 8'h06);
    // R12 writes to read-only / unassigned offsets
    wr(8'h00, 8'h55); rd(8'h00, v); cmp("R12", v, 8'h0D);
    wr(8'h01, 8'h77); rd(8'h01, v); cmp("R12", v, 8'h00);
    wr(8'h0F, 8'h10); rd(8'h0F, v); cmp("R12", v, 8'h00);
    wr(8'h13, 8'h10); rd(8'h13, v); cmp("R12", v, 8'h00);
    // R4..R7 per-port routing through the bank window
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 18; k++) begin
        wr(8'h0A, 8'(p));
        wr(8'h10, codes[k]);
        wr(8'h11, codes[(k + 5) % 18]);
        wr(8'h12, codes[(k + 11) % 18]);
        repeat (2) @(posedge clk);
      end
    // R3 readback per port
    for (int p = 0; p < 8; p++) begin
      wr(8'h0A, 8'(p));
      rd(8'h10, v); cmp("R3", v, codes[17]);
      rd(8'h11, v); cmp("R3", v, codes[4]);
      rd(8'h12, v); cmp("R3", v, codes[10]);
    end
    // R13 pointer out of range
    wr(8'h0A, 8'h08); wr(8'h10, 8'h12); rd(8'h10, v); cmp("R13", v, 8'h00);
    wr(8'h0A, 8'hFF); wr(8'h12, 8'h15); rd(8'h12, v); cmp("R13", v, 8'h00);
    wr(8'h0A, 8'h00); rd(8'h10, v); cmp("R13", v, codes[17]);
    rd(8'h12, v); cmp("R13", v, codes[10]);
    // R8 tester selects
    for (int k = 0; k < 18; k++) begin
      wr(8'h0B, codes[k]);
      wr(8'h0C, codes[(k + 3) % 18]);
      wr(8'h0D, codes[(k + 7) % 18]);
      repeat (3) @(posedge clk);
    end
    // R10 serial mode pins
    wr(8'h08, 8'h38); @(negedge clk);
    cmp("R10", {5'd0, dev_mode, dev_swap, dev_edge}, 8'h03);
    wr(8'h08, 8'h30); @(negedge clk);
    cmp("R10", {5'd0, dev_mode, dev_swap, dev_edge}, 8'h04);
    // R9 R10 R11 full control sweep
    for (int c = 0; c < 256; c++) begin
      wr(8'h08, 8'(c));
      rd(8'h08, v);
      cmp("R11", v & 8'h7F, 8'(c) & 8'h7F);
      repeat (2) @(posedge clk);
    end
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule